// File: doc/BRIEF.md
# SSI Master Position Reader

This block is the controller end of a synchronous serial position link. When a read is requested it drives a burst of clock pulses toward an absolute position sensor. The sensor answers with one bit per clock period, most significant position bit first. After the position bits come an active-low health bit and an even-parity bit. Any surplus clocks beyond that payload return zero padding. The block rebuilds the position word, reports a slave fault, and flags a parity mismatch or a non-zero padding bit.

A system clock divider sets the serial clock rate. It should be programmed so that the link stays at or below 2 Mbit/s. The clock count per read is also programmable, and any value shorter than the payload is raised to the payload length. At the end of each burst the serial clock rests high for a programmable recovery interval, so that the sensor can release its data line. Only after that interval is a new read accepted. The host starts a read with a one-cycle request and collects the result on a one-cycle done strobe.

Top module: `ssi_pos_reader`

## Requirements
- R1: After reset and between reads, `ssi_clk` is 1, `busy` and `done` are 0, and `position`, `fault` and `parity_err` are 0 until the first read completes.
- R2: A read issues exactly max(`clk_count`, POS_W+2) falling edges on `ssi_clk`. The payload is POS_W position bits, one health bit and one parity bit.
- R3: Each low phase and each high phase of `ssi_clk` lasts `half_div`+1 system clocks.
- R4: The bit sampled in clock period k (k = 1..POS_W) becomes `position` bit POS_W-k, so the first received bit is the MSB. Sampling takes place at the end of each high phase.
- R5: The health bit is sampled in period POS_W+1. `fault` is 1 when this bit is 0 and 0 when it is 1.
- R6: The parity bit is sampled in period POS_W+2. If the XOR of the position bits, the health bit and the parity bit is 1, `parity_err` is 1.
- R7: A 1 received in any period after POS_W+2 sets `parity_err`.
- R8: `done` is high for exactly one system clock per read. From that clock on, `position`, `fault` and `parity_err` hold the new result until the next read completes.
- R9: After `done`, `ssi_clk` stays 1 and `busy` stays 1 for `mono_len`+1 system clocks, counting the `done` clock itself. A `start` received while `busy` is 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle read request |
| ssi_data | input | 1 | Serial data returned by the sensor |
| clk_count | input | CNT_W | Clock pulses per read (raised to the payload length if smaller) |
| half_div | input | DIV_W | Half period of `ssi_clk`, minus one, in system clocks |
| mono_len | input | MONO_W | Recovery interval after a burst, minus one, in system clocks |
| ssi_clk | output | 1 | Serial clock to the sensor, idle high |
| busy | output | 1 | A burst or recovery interval is in progress |
| done | output | 1 | One-cycle strobe: the result is valid |
| position | output | POS_W | Reconstructed position word |
| fault | output | 1 | Sensor reported a fault (health bit was 0) |
| parity_err | output | 1 | Parity mismatch or non-zero padding |

## Verification
The bench builds the block with its default parameters. These are a 12-bit position, a 6-bit clock count, an 8-bit divider and a 12-bit recovery counter, which give a 14-bit payload. With these values, clock counts below the payload (clamped up to it), exactly at it, and up to the 63-pulse maximum can all be reached. Divider settings of 0 to 3 exercise both the single-cycle half period and longer ones. Short recovery settings make the end of the recovery interval observable cycle by cycle, together with start requests that land inside the burst and inside the recovery interval.

// File: rtl/ssi_pkg.sv
package ssi_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_HIGH = 2'd2,
    ST_MONO = 2'd3
  } ssi_state_e;
endpackage

// File: rtl/ssi_half_timer.sv
module ssi_half_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] half_div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  assign tick = run && (cnt_q == half_div);

  always_ff @(posedge clk) begin
    if (rst || !run || tick) cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end

  assert_half_in_range_R3: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt_q <= half_div));
endmodule

// File: rtl/ssi_frame_rx.sv
module ssi_frame_rx #(
  parameter int POS_W     = 12,
  parameter int PARITY_EN = 1,
  parameter int IDX_W     = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             sample,
  input  logic             last,
  input  logic [IDX_W-1:0] idx,
  input  logic             din,
  output logic [POS_W-1:0] position,
  output logic             fault,
  output logic             parity_err,
  output logic             done
);
  localparam int PAY_W = POS_W + 1 + PARITY_EN;

  logic [POS_W-1:0] pos_acc, pos_n;
  logic             err_acc, err_n;
  logic             par_acc, par_n;
  logic             pad_acc, pad_n;
  logic             is_pos, is_err, is_pay;
  logic             par_bad;

  assign is_pos = idx < IDX_W'(POS_W);
  assign is_err = idx == IDX_W'(POS_W);
  assign is_pay = idx < IDX_W'(PAY_W);

  always_comb begin
    pos_n = is_pos ? {pos_acc[POS_W-2:0], din} : pos_acc;
    err_n = is_err ? din : err_acc;
    par_n = par_acc ^ (is_pay & din);
    pad_n = pad_acc | (~is_pay & din);
  end

  generate
    if (PARITY_EN != 0) begin : g_par
      assign par_bad = par_n;
    end else begin : g_nopar
      assign par_bad = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      pos_acc <= '0;
      err_acc <= 1'b0;
      par_acc <= 1'b0;
      pad_acc <= 1'b0;
    end else if (sample) begin
      pos_acc <= pos_n;
      err_acc <= err_n;
      par_acc <= par_n;
      pad_acc <= pad_n;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      position   <= '0;
      fault      <= 1'b0;
      parity_err <= 1'b0;
      done       <= 1'b0;
    end else begin
      done <= sample && last;
      if (sample && last) begin
        position   <= pos_n;
        fault      <= ~err_n;
        parity_err <= par_bad | pad_n;
      end
    end
  end

  assert_fault_active_low_R5: assert property (@(posedge clk) disable iff (rst)
    done |-> (fault == !err_acc));
  assert_pos_matches_acc_R4: assert property (@(posedge clk) disable iff (rst)
    done |-> (position == pos_acc));
  assert_pad_flag_R7: assert property (@(posedge clk) disable iff (rst)
    (done && pad_acc) |-> parity_err);
endmodule

// File: rtl/ssi_pos_reader.sv
module ssi_pos_reader
  import ssi_pkg::*;
#(
  parameter int POS_W     = 12,
  parameter int PARITY_EN = 1,
  parameter int CNT_W     = 6,
  parameter int DIV_W     = 8,
  parameter int MONO_W    = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              ssi_data,
  input  logic [CNT_W-1:0]  clk_count,
  input  logic [DIV_W-1:0]  half_div,
  input  logic [MONO_W-1:0] mono_len,
  output logic              ssi_clk,
  output logic              busy,
  output logic              done,
  output logic [POS_W-1:0]  position,
  output logic              fault,
  output logic              parity_err
);
  localparam int PAY_W = POS_W + 1 + PARITY_EN;

  ssi_state_e        state_q;
  logic              sclk_q;
  logic [CNT_W-1:0]  bit_idx, n_last, total;
  logic [MONO_W-1:0] mono_cnt;
  logic              tick, run, accept, sample, last;

  assign total  = (clk_count < CNT_W'(PAY_W)) ? CNT_W'(PAY_W) : clk_count;
  assign run    = (state_q == ST_LOW) || (state_q == ST_HIGH);
  assign accept = (state_q == ST_IDLE) && start;
  assign sample = (state_q == ST_HIGH) && tick;
  assign last   = bit_idx == n_last;

  ssi_half_timer #(.DIV_W(DIV_W)) u_timer (
    .clk(clk), .rst(rst), .run(run), .half_div(half_div), .tick(tick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      sclk_q   <= 1'b1;
      bit_idx  <= '0;
      n_last   <= '0;
      mono_cnt <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start) begin
          state_q <= ST_LOW;
          sclk_q  <= 1'b0;
          bit_idx <= '0;
          n_last  <= total - 1'b1;
        end
        ST_LOW: if (tick) begin
          state_q <= ST_HIGH;
          sclk_q  <= 1'b1;
        end
        ST_HIGH: if (tick) begin
          if (last) begin
            state_q  <= ST_MONO;
            mono_cnt <= '0;
          end else begin
            bit_idx <= bit_idx + 1'b1;
            state_q <= ST_LOW;
            sclk_q  <= 1'b0;
          end
        end
        ST_MONO: begin
          if (mono_cnt == mono_len) state_q <= ST_IDLE;
          else                      mono_cnt <= mono_cnt + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign ssi_clk = sclk_q;
  assign busy    = state_q != ST_IDLE;

  ssi_frame_rx #(.POS_W(POS_W), .PARITY_EN(PARITY_EN), .IDX_W(CNT_W)) u_rx (
    .clk(clk), .rst(rst), .clr(accept), .sample(sample), .last(last),
    .idx(bit_idx), .din(ssi_data),
    .position(position), .fault(fault), .parity_err(parity_err), .done(done)
  );

  assert_idle_clk_high_R1: assert property (@(posedge clk) disable iff (rst)
    !run |-> ssi_clk);
  assert_idx_bound_R2: assert property (@(posedge clk) disable iff (rst)
    busy |-> (bit_idx <= n_last));
  assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_done_enters_mono_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> (state_q == ST_MONO));
  assert_start_ignored_R9: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_MONO && start) |=> (state_q != ST_LOW));
endmodule

// File: tb/sim_ssi_pos_reader.sv
module sim_ssi_pos_reader;
  localparam int POS_W = 12;
  localparam int PAY_W = POS_W + 2;
  localparam int NV    = 8;

  // {pos[12], health, flip_parity, pad_one, clk_count[6], half_div[8]}
  localparam logic [28:0] VEC [NV] = '{
    {12'hA5C, 1'b1, 1'b0, 1'b0, 6'd14, 8'd0},
    {12'h001, 1'b1, 1'b0, 1'b0, 6'd20, 8'd1},
    {12'hFFF, 1'b0, 1'b0, 1'b0, 6'd14, 8'd2},
    {12'h800, 1'b1, 1'b1, 1'b0, 6'd16, 8'd0},
    {12'h3C3, 1'b1, 1'b0, 1'b1, 6'd18, 8'd1},
    {12'h000, 1'b1, 1'b0, 1'b0, 6'd5,  8'd0},
    {12'h7E1, 1'b0, 1'b1, 1'b0, 6'd63, 8'd3},
    {12'h555, 1'b1, 1'b0, 1'b0, 6'd15, 8'd0}
  };

  logic clk = 1'b0;
  logic rst, start, ssi_data;
  logic [5:0]  clk_count;
  logic [7:0]  half_div;
  logic [11:0] mono_len;
  logic ssi_clk, busy, done, fault, parity_err;
  logic [POS_W-1:0] position;

  int checks = 0, errors = 0;
  int fall_cnt = 0, low_cnt = 0, tx_i = 0;
  logic [63:0] tx_frame = '0;
  bit finished = 0;

  always #2 clk = ~clk;

  ssi_pos_reader u0 (
    .clk(clk), .rst(rst), .start(start), .ssi_data(ssi_data),
    .clk_count(clk_count), .half_div(half_div), .mono_len(mono_len),
    .ssi_clk(ssi_clk), .busy(busy), .done(done), .position(position),
    .fault(fault), .parity_err(parity_err)
  );

  // sensor model: presents the next frame bit on each rising clock edge
  always @(posedge ssi_clk) begin
    ssi_data <= tx_frame[63 - tx_i];
    tx_i <= tx_i + 1;
  end
  always @(negedge ssi_clk) fall_cnt <= fall_cnt + 1;
  always @(negedge clk) if (ssi_clk === 1'b0) low_cnt <= low_cnt + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic load_frame(input logic [11:0] p, input logic hb,
                            input logic flip, input logic padone);
    logic par;
    par = (^p) ^ hb ^ flip;
    tx_frame = {p, hb, par, 50'b0};
    if (padone) tx_frame[63 - PAY_W] = 1'b1;
    tx_i = 0;
    fall_cnt = 0;
    low_cnt = 0;
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic wait_done(output bit got);
    int t = 0;
    while (done !== 1'b1 && t < 20000) begin
      @(negedge clk);
      t++;
    end
    got = (done === 1'b1);
  endtask

  task automatic wait_idle();
    int t = 0;
    while (busy !== 1'b0 && t < 20000) begin
      @(negedge clk);
      t++;
    end
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    finish_run();
  end

  initial begin
    bit got;
    int exp_f;
    rst = 1'b1; start = 1'b0; ssi_data = 1'b1;
    clk_count = 6'd14; half_div = 8'd0; mono_len = 12'd7;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check(ssi_clk === 1'b1 && busy === 1'b0 && done === 1'b0, "R1 idle lines",
          {ssi_clk, busy, done}, 3'b100);
    check(position === '0 && fault === 1'b0 && parity_err === 1'b0, "R1 reset outputs",
          {position, fault, parity_err}, 0);

    for (int v = 0; v < NV; v++) begin
      logic [11:0] p; logic hb, fl, pd; logic [5:0] nc; logic [7:0] hd;
      {p, hb, fl, pd, nc, hd} = VEC[v];
      exp_f = (nc < PAY_W) ? PAY_W : nc;
      clk_count = nc; half_div = hd;
      load_frame(p, hb, fl, pd);
      pulse_start();
      wait_done(got);
      check(got, "R8 done seen", got, 1);
      check(position === p, "R4 position MSB first", position, p);
      check(fault === ~hb, "R5 fault from health bit", fault, ~hb);
      check(parity_err === (fl | pd), "R6 R7 parity/pad flag", parity_err, fl | pd);
      check(fall_cnt == exp_f, "R2 falling edge count", fall_cnt, exp_f);
      check(low_cnt == exp_f * (hd + 1), "R3 low phase length", low_cnt, exp_f * (hd + 1));
      @(negedge clk);
      check(done === 1'b0, "R8 done one cycle", done, 0);
      wait_idle();
      repeat (3) @(negedge clk);
      check(position === p && ssi_clk === 1'b1, "R8 R1 result held, clock idle high",
            {position, ssi_clk}, {p, 1'b1});
    end

    // R9: start during burst and during recovery is ignored; recovery length
    clk_count = 6'd16; half_div = 8'd1; mono_len = 12'd3;
    load_frame(12'h2B4, 1'b1, 1'b0, 1'b0);
    pulse_start();
    repeat (9) @(negedge clk);
    start = 1'b1;
    @(negedge clk) start = 1'b0;
    wait_done(got);
    check(got && fall_cnt == 16, "R9 start in burst ignored", fall_cnt, 16);
    begin
      int hold = 0;
      bit clk_hi = 1;
      while (busy === 1'b1 && hold < 100) begin
        if (ssi_clk !== 1'b1) clk_hi = 0;
        if (hold == 1) start = 1'b1;
        else start = 1'b0;
        hold++;
        @(negedge clk);
      end
      start = 1'b0;
      check(hold == 4, "R9 recovery length", hold, 4);
      check(clk_hi, "R9 clock high in recovery", clk_hi, 1);
    end
    repeat (10) @(negedge clk);
    check(fall_cnt == 16 && busy === 1'b0, "R9 start in recovery ignored", fall_cnt, 16);
    check(position === 12'h2B4 && parity_err === 1'b0, "R4 R6 directed read",
          position, 12'h2B4);

    // R7: padding 1 in the very last surplus period with the largest count
    clk_count = 6'd63; half_div = 8'd0; mono_len = 12'd0;
    load_frame(12'h0F0, 1'b1, 1'b0, 1'b0);
    tx_frame[63 - 62] = 1'b1;
    pulse_start();
    wait_done(got);
    check(parity_err === 1'b1 && fault === 1'b0, "R7 last pad bit", parity_err, 1);
    wait_idle();
    // R1: reset mid-burst returns clock high
    load_frame(12'h111, 1'b1, 1'b0, 1'b0);
    pulse_start();
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    check(ssi_clk === 1'b1 && busy === 1'b0 && position === '0, "R1 reset mid-burst",
          {ssi_clk, busy}, 2'b10);
    finish_run();
  end
endmodule